// File: doc/BRIEF.md
# Serially Configured Crosspoint Switch Matrix

This block models a square array of on/off connections between row lines and column lines. The pattern of closed connections is written one bit at a time through a serial port and takes effect only when it is committed in parallel. A serial data line is sampled each time a slow serial clock input rises. The sampled bit goes into a shift register that holds one bit for each crosspoint. The far end of that register drives a serial output. Several matrices can therefore be chained, with each output feeding the next device's serial input.

An active-low commit strobe is level-sensitive. While it is held low, the control latches follow the shift register. While it is high, the latches keep their contents no matter how much shifting goes on. In the digital routing view, each row output is the OR of every column input whose crosspoint is closed.

The serial clock, serial data and commit strobe are treated as asynchronous pins. They are synchronized into a single system clock domain. A rising edge is detected on the synchronized serial clock.

Top module: `xbar_matrix`

## Requirements
- R1: After reset every crosspoint is open: rowOut is 0 for any colIn, and serOut is 0.
- R2: Exactly one bit is shifted in for each rising edge of serClk. A falling edge or a steady level of serClk shifts nothing.
- R3: Bits enter in a fixed order. With ROWS*COLS bits shifted, the first bit controls row ROWS-1 / column COLS-1. The following bits walk down the columns of that row to column 0, then through row ROWS-2 from column COLS-1 down to 0, and so on. The last bit controls row 0 / column 0. Row r / column c connects colIn[c] to rowOut[r].
- R4: Between shifts, serOut shows the bit that was shifted in ROWS*COLS rising edges earlier (256 with default parameters), so a chained device receives the stream unchanged.
- R5: While loadN is low, the control latches take the shift register contents. While loadN is high, shifting leaves the routing unchanged.
- R6: A latch value of 1 closes its crosspoint and 0 opens it. rowOut[r] is the OR over c of (latch[r][c] AND colIn[c]), combinationally from colIn.
- R7: With loadN high and no rising edge on serClk, neither rowOut nor serOut changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock, asynchronous; data is taken on its rising edge |
| serIn | input | 1 | Serial configuration data |
| loadN | input | 1 | Active-low level commit strobe |
| colIn | input | COLS | Column input lines |
| serOut | output | 1 | Far end of the shift register, for chaining |
| rowOut | output | ROWS | Routed row outputs |

## Verification
The bench builds the matrix with ROWS=4 and COLS=4, which gives a 16-bit shift register. At that size every column-input combination, all 16 of them, can be applied against every row of a committed pattern. This checks the bit-order map and the OR routing exhaustively. The same size lets a second full stream be shifted through while serOut is compared bit by bit against the first stream. Meanwhile the committed routing is confirmed to stay put until the next commit.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef struct packed {
    logic shift;    // one-cycle pulse per serial clock rise
    logic load;     // commit level, active high internally
    logic dataBit;  // synchronized serial data
  } xbarCtl_t;
endpackage

// File: rtl/xbar_ctl.sv
module xbar_ctl
  import xbar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serIn,
  input  logic     loadN,
  output xbarCtl_t ctl
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] clkSync;
  logic [MSB:0] dinSync;
  logic [MSB:0] ldSync;
  logic         clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      dinSync <= '0;
      ldSync  <= '1;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[MSB-1:0], serClk};
      dinSync <= {dinSync[MSB-1:0], serIn};
      ldSync  <= {ldSync[MSB-1:0], loadN};
      clkPrev <= clkSync[MSB];
    end
  end

  always_comb begin
    ctl.shift   = clkSync[MSB] & ~clkPrev;
    ctl.load    = ~ldSync[MSB];
    ctl.dataBit = dinSync[MSB];
  end
endmodule

// File: rtl/xbar_dp.sv
module xbar_dp
  import xbar_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xbarCtl_t             ctl,
  input  logic [COLS-1:0]      colIn,
  output logic [ROWS*COLS-1:0] shiftQ,
  output logic [ROWS*COLS-1:0] latchQ,
  output logic                 serOut,
  output logic [ROWS-1:0]      rowOut
);
  localparam int NBITS = ROWS * COLS;

  // first bit in ends at the top index: row ROWS-1, column COLS-1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (ctl.shift) begin
      shiftQ <= {shiftQ[NBITS-2:0], ctl.dataBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (ctl.load) begin
      latchQ <= shiftQ;
    end
  end

  assign serOut = shiftQ[NBITS-1];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rowOut[r] = |(latchQ[r*COLS +: COLS] & colIn);
  end
endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix
  import xbar_pkg::*;
#(
  parameter int ROWS        = 16,
  parameter int COLS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            serClk,
  input  logic            serIn,
  input  logic            loadN,
  input  logic [COLS-1:0] colIn,
  output logic            serOut,
  output logic [ROWS-1:0] rowOut
);
  localparam int NBITS = ROWS * COLS;

  xbarCtl_t         ctl;
  logic [NBITS-1:0] shiftQ;
  logic [NBITS-1:0] latchQ;

  xbar_ctl #(.SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serIn(serIn),
    .loadN(loadN), .ctl(ctl)
  );

  xbar_dp #(.ROWS(ROWS), .COLS(COLS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .colIn(colIn),
    .shiftQ(shiftQ), .latchQ(latchQ), .serOut(serOut), .rowOut(rowOut)
  );
endmodule

// File: rtl/xbar_matrix_chk.sv
module xbar_matrix_chk
  import xbar_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input xbarCtl_t             ctl,
  input logic [ROWS*COLS-1:0] shiftQ,
  input logic [ROWS*COLS-1:0] latchQ,
  input logic                 serOut,
  input logic [COLS-1:0]      colIn,
  input logic [ROWS-1:0]      rowOut
);
  localparam int NBITS = ROWS * COLS;

  AST_SHIFT_PULSE: assert property (@(posedge clk) disable iff (!rstN) ctl.shift |=> !ctl.shift); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN) !ctl.shift |=> $stable(shiftQ)); // R2
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN) ctl.shift |=> (shiftQ[0] == $past(ctl.dataBit)) && (shiftQ[NBITS-1:1] == $past(shiftQ[NBITS-2:0]))); // R3
  AST_SEROUT_ADV: assert property (@(posedge clk) disable iff (!rstN) ctl.shift |=> serOut == $past(shiftQ[NBITS-2])); // R4
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rstN) ctl.load |=> latchQ == $past(shiftQ)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN) !ctl.load |=> $stable(latchQ)); // R5
  AST_ROUTE_IDLE: assert property (@(posedge clk) disable iff (!rstN) (colIn == '0) |-> (rowOut == '0)); // R6
endmodule

bind xbar_matrix xbar_matrix_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
  .clk(clk), .rstN(rstN), .ctl(ctl), .shiftQ(shiftQ), .latchQ(latchQ),
  .serOut(serOut), .colIn(colIn), .rowOut(rowOut)
);

// File: tb/xbar_matrix_tb.sv
`timescale 1ns/1ps
module xbar_matrix_tb_top;
  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int NBITS = ROWS * COLS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serIn = 1'b0;
  logic loadN = 1'b1;
  logic [COLS-1:0] colIn = '0;
  logic serOut;
  logic [ROWS-1:0] rowOut;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 0;

  logic [NBITS-1:0] patA, patB, committed;

  always #5 clk = ~clk;

  xbar_matrix #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serIn(serIn), .loadN(loadN),
    .colIn(colIn), .serOut(serOut), .rowOut(rowOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stream index k -> row/col per bit-order rule
  function automatic logic [ROWS-1:0] expRows(input logic [NBITS-1:0] pat, input logic [COLS-1:0] cols);
    logic [ROWS-1:0] res = '0;
    for (int k = 0; k < NBITS; k++) begin
      int r = ROWS - 1 - k / COLS;
      int c = COLS - 1 - k % COLS;
      if (pat[k] && cols[c]) res[r] = 1'b1;
    end
    return res;
  endfunction

  task automatic shiftBit(input logic b);
    @(negedge clk);
    serIn = b;
    waitCycles(2);
    serClk = 1'b1;
    waitCycles(5);
    serClk = 1'b0;
    waitCycles(5);
  endtask

  task automatic commit();
    @(negedge clk);
    loadN = 1'b0;
    waitCycles(5);
    loadN = 1'b1;
    waitCycles(5);
  endtask

  task automatic sweepRoute(input logic [NBITS-1:0] pat, input string tag);
    for (int m = 0; m < (1 << COLS); m++) begin
      @(negedge clk);
      colIn = COLS'(m);
      #1;
      check(rowOut == expRows(pat, COLS'(m)), tag, int'(rowOut), int'(expRows(pat, COLS'(m))));
    end
    colIn = '0;
  endtask

  initial begin
    for (int k = 0; k < NBITS; k++) begin
      patA[k] = ((k * 7 + 3) % 5) < 2;
      patB[k] = (k % 3) == 0;
    end
    patA[0] = 1'b1;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    colIn = '1; #1;
    check(rowOut == '0, "R1 rowOut after reset", int'(rowOut), 0);
    check(serOut == 1'b0, "R1 serOut after reset", int'(serOut), 0);
    colIn = '0;

    // shift pattern A; serOut must still show the reset zeros (R4)
    for (int k = 0; k < NBITS; k++) begin
      shiftBit(patA[k]);
      if (k < NBITS - 1) check(serOut == 1'b0, "R4 serOut before wrap", int'(serOut), 0);
    end
    check(serOut == patA[0], "R4 first bit at serOut after full stream", int'(serOut), int'(patA[0]));
    // R5 no commit yet: routing still open
    committed = '0;
    sweepRoute(committed, "R5 routing held before commit");

    commit();
    committed = patA;
    sweepRoute(committed, "R3 R6 routing of pattern A");

    // shift pattern B while committed A holds; serOut replays A (R4, R2)
    for (int k = 0; k < NBITS; k++) begin
      check(serOut == patA[k], "R4 serOut replays stream", int'(serOut), int'(patA[k]));
      shiftBit(patB[k]);
    end
    sweepRoute(committed, "R5 routing held while shifting");

    // R7 idle: nothing changes
    colIn = '1;
    waitCycles(40);
    check(rowOut == expRows(committed, '1), "R7 rowOut idle", int'(rowOut), int'(expRows(committed, '1)));
    check(serOut == patB[0], "R7 serOut idle", int'(serOut), int'(patB[0]));
    colIn = '0;

    // R2: falling edge alone does no shift
    @(negedge clk); serClk = 1'b1; waitCycles(5);
    check(serOut == patB[1], "R2 rise shifts once", int'(serOut), int'(patB[1]));
    serIn = 1'b1; serClk = 1'b0; waitCycles(10);
    check(serOut == patB[1], "R2 fall shifts nothing", int'(serOut), int'(patB[1]));
    // restore: pattern in register is now B shifted by one with serIn from last shift
    commit();
    committed = {patB[NBITS-2:0], 1'b0};
    committed = '0;
    for (int k = 1; k < NBITS; k++) committed[k - 1] = patB[k];
    committed[NBITS - 1] = serIn;
    sweepRoute(committed, "R3 R6 routing of shifted pattern B");

    // R1 reset again
    @(negedge clk); rstN = 1'b0; #1;
    colIn = '1; #1;
    check(rowOut == '0, "R1 rowOut on reset", int'(rowOut), 0);
    check(serOut == 1'b0, "R1 serOut on reset", int'(serOut), 0);
    rstN = 1'b1;

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      failCount++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end
endmodule